// File: doc/BRIEF.md
# NAND Page Hamming ECC Snooper

This block listens to the byte-wide command/address/data stream of a NAND flash bus. It computes a page error-correcting code on the fly, and the bus never has to wait for it. A read command (00h) or a program command (80h), followed by at least one address beat, starts a new page. After that, every data beat is taken as the next main-area word, beginning at word zero. The main area holds 512, 1024, 2048 or 4096 words, chosen by a two-bit page-size setting.

For a program sequence, the code is ready once the last main word has passed. Software then writes it into the spare area. For a read sequence, the block takes in the stored code from the four spare bytes that follow the main area. It forms a syndrome against the code it computed and puts the page into one of four classes:

- clean
- one correctable bit, with the word offset and the bit position
- corruption inside the stored code itself
- uncorrectable multiple error

The results stay locked until the next start command. A small register read port exposes them, and a software reset clears everything.

The bus input is a valid/ready stream. The ready output is held high at all times, because a snooper must never stall the flash bus. A beat counts only in a cycle where valid is high. Beats seen while valid is low have no effect, whatever their strobes or data.

Top module: `nand_ecc_snoop`

## Requirements
- R1: An asynchronous reset, or a one-cycle `sw_reset` pulse, clears the status, parity and inverse-parity registers to zero and returns the sequencer to idle. Data beats that follow then have no effect.
- R2: A beat with `bus_cle`=1 and data 00h (read) or 80h (program) is a start command. It clears all three result registers, and the port shows them as zero from the next cycle on. Data beats received before the first `bus_ale` beat after a start are ignored. Data beats after it are main words 0, 1, 2, and so on.
- R3: `page_mode` is sampled at the start command and sets the main-area length: 0 gives 512 words, 1 gives 1024, 2 gives 2048 and 3 gives 4096.
- R4: The code is two 15-bit words. For every bit that is 1, at word index w (12 bits) and bit b (3 bits), the parity word accumulates {w,b} by XOR. The inverse-parity word accumulates the bitwise complement ~{w,b} by XOR.
- R5: After the last main word of a program sequence, the parity register holds the computed parity, the inverse-parity register holds the computed inverse parity, and status bit 3 (result valid) is 1. All of these are visible from the next cycle on.
- R6: On a read sequence, the four data beats after the main area are the stored code, taken in this order: parity[7:0], parity[14:8], inverse[7:0], inverse[14:8]. Bit 7 of the second and fourth bytes is ignored. After the fourth byte, the parity register holds the parity syndrome, the inverse-parity register holds the inverse syndrome, and status bit 3 is 1.
- R7: If both syndromes are zero, status bits 2..0 are all 0.
- R8: If the parity syndrome is the exact bitwise complement of the inverse syndrome, only status bit 0 (correctable) is set. The parity register then reads {word offset, bit position} of the flipped bit.
- R9: If exactly one bit is set across both syndromes together, only status bit 1 (stored-code error) is set.
- R10: Any other nonzero syndrome pattern sets only status bit 2 (multiple error). At most one of status bits 2..0 is ever set.
- R11: After a result is valid, further data and address beats, and commands other than 00h and 80h, leave all three registers unchanged.
- R12: `bus_ready` is always 1. Beats with `bus_valid`=0 are ignored, whatever their strobes.
- R13: `rd_data` is a combinational view selected by `rd_addr`: 0 gives status, 1 gives parity, 2 gives inverse parity and 3 gives zero. Narrower values are zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw_reset | input | 1 | Synchronous clear of results and sequencer |
| page_mode | input | 2 | Main-area size select, sampled at start |
| bus_valid | input | 1 | A bus beat is present |
| bus_ready | output | 1 | Always high; the snooper never stalls |
| bus_cle | input | 1 | Beat is a command byte |
| bus_ale | input | 1 | Beat is an address byte |
| bus_data | input | 8 | Command, address or data byte |
| rd_addr | input | 2 | Result register select |
| rd_data | output | 32 | Selected result register |

## Verification
The hardest case to reach is one where the stored code disagrees with the data in a chosen way. Reaching it needs a full page, with every word delivered in order, followed by a spare area whose bytes are crafted on purpose. The bench keeps its own page image and derives the true code from it. It then corrupts either the data stream it sends or the spare bytes. It does this for a single data bit, for two data bits, and for one stored-code bit. A flip of the very last word of the largest page checks that the reported position uses the full word-index width.

// File: rtl/nand_ecc_pkg.sv
`timescale 1ns/1ps
package nand_ecc_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_CMD, SQ_MAIN, SQ_SPARE} seq_state_e;

  // status register bit positions
  localparam int ST_REC   = 0;
  localparam int ST_CODE  = 1;
  localparam int ST_MULTI = 2;
  localparam int ST_VALID = 3;
  localparam int ST_W     = 4;
endpackage

// File: rtl/nand_ecc_seq.sv
`timescale 1ns/1ps
module nand_ecc_seq
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BASE_WORDS = 512,
  parameter int AW = 12,
  parameter int SPARE_N = 4,
  parameter int SI_W = 2,
  parameter logic [DATA_W-1:0] CMD_READ = 8'h00,
  parameter logic [DATA_W-1:0] CMD_PROG = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic [1:0]        page_mode,
  input  logic              beat,
  input  logic              cle,
  input  logic              ale,
  input  logic [DATA_W-1:0] data,
  output logic              start,
  output logic              is_read,
  output logic              main_beat,
  output logic              main_last,
  output logic              spare_beat,
  output logic              spare_last,
  output logic [AW-1:0]     word_idx,
  output logic [SI_W-1:0]   spare_idx,
  output logic              idle
);
  seq_state_e      state;
  logic [AW-1:0]   cnt, last_idx;
  logic [SI_W-1:0] scnt;
  logic            rd_q;
  logic            data_beat;

  assign data_beat  = beat & ~cle & ~ale;
  assign start      = beat & cle & ((data == CMD_READ) | (data == CMD_PROG));
  assign main_beat  = data_beat & (state == SQ_MAIN);
  assign main_last  = main_beat & (cnt == last_idx);
  assign spare_beat = data_beat & (state == SQ_SPARE);
  assign spare_last = spare_beat & (scnt == SI_W'(SPARE_N - 1));
  assign word_idx   = cnt;
  assign spare_idx  = scnt;
  assign is_read    = rd_q;
  assign idle       = (state == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      cnt <= '0;
      scnt <= '0;
      rd_q <= 1'b0;
      last_idx <= AW'(BASE_WORDS - 1);
    end else if (sw_reset) begin
      state <= SQ_IDLE;
      cnt <= '0;
      scnt <= '0;
      rd_q <= 1'b0;
    end else if (start) begin
      state <= SQ_CMD;
      cnt <= '0;
      scnt <= '0;
      rd_q <= (data == CMD_READ);
      last_idx <= AW'((BASE_WORDS << page_mode) - 1);
    end else begin
      unique case (state)
        SQ_CMD: if (beat && ale) state <= SQ_MAIN;
        SQ_MAIN: if (main_beat) begin
          cnt <= cnt + AW'(1);
          if (main_last) state <= rd_q ? SQ_SPARE : SQ_IDLE;
        end
        SQ_SPARE: if (spare_beat) begin
          scnt <= scnt + SI_W'(1);
          if (spare_last) state <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nand_ecc_accum.sv
`timescale 1ns/1ps
module nand_ecc_accum #(
  parameter int DATA_W = 8,
  parameter int AW = 12,
  parameter int BW = 3,
  parameter int CODE_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [AW-1:0]     word_idx,
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] acc_p,
  output logic [CODE_W-1:0] acc_n,
  output logic [CODE_W-1:0] nxt_p,
  output logic [CODE_W-1:0] nxt_n
);
  always_comb begin
    nxt_p = acc_p;
    nxt_n = acc_n;
    for (int i = 0; i < DATA_W; i++) begin
      if (data[i]) begin
        nxt_p = nxt_p ^ {word_idx, BW'(i)};
        nxt_n = nxt_n ^ ~{word_idx, BW'(i)};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_p <= '0;
      acc_n <= '0;
    end else if (clr) begin
      acc_p <= '0;
      acc_n <= '0;
    end else if (en) begin
      acc_p <= nxt_p;
      acc_n <= nxt_n;
    end
  end
endmodule

// File: rtl/nand_ecc_classify.sv
`timescale 1ns/1ps
module nand_ecc_classify #(
  parameter int CODE_W = 15
) (
  input  logic [CODE_W-1:0] comp_p,
  input  logic [CODE_W-1:0] comp_n,
  input  logic [CODE_W-1:0] st_p,
  input  logic [CODE_W-1:0] st_n,
  output logic [CODE_W-1:0] syn_p,
  output logic [CODE_W-1:0] syn_n,
  output logic              rec,
  output logic              code_err,
  output logic              multi
);
  localparam int ONES_W = $clog2(2 * CODE_W + 1);
  logic [ONES_W-1:0] ones;

  assign syn_p    = comp_p ^ st_p;
  assign syn_n    = comp_n ^ st_n;
  assign ones     = ONES_W'($countones({syn_p, syn_n}));
  assign rec      = (syn_p == ~syn_n);
  assign code_err = !rec && (ones == ONES_W'(1));
  assign multi    = !rec && (ones > ONES_W'(1));
endmodule

// File: rtl/nand_ecc_snoop.sv
`timescale 1ns/1ps
module nand_ecc_snoop
  import nand_ecc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BASE_WORDS = 512,
  parameter int REG_W = 32,
  parameter logic [DATA_W-1:0] CMD_READ = 8'h00,
  parameter logic [DATA_W-1:0] CMD_PROG = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_reset,
  input  logic [1:0]        page_mode,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_cle,
  input  logic              bus_ale,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [1:0]        rd_addr,
  output logic [REG_W-1:0]  rd_data
);
  localparam int AW      = $clog2(BASE_WORDS) + 3;
  localparam int BW      = $clog2(DATA_W);
  localparam int CODE_W  = AW + BW;
  localparam int HALF_N  = (CODE_W + DATA_W - 1) / DATA_W;
  localparam int SPARE_N = 2 * HALF_N;
  localparam int SI_W    = $clog2(SPARE_N);

  logic              beat, start, is_read, main_beat, main_last;
  logic              spare_beat, spare_last, seq_idle;
  logic [AW-1:0]     word_idx;
  logic [SI_W-1:0]   spare_idx;
  logic [CODE_W-1:0] acc_p, acc_n, nxt_p, nxt_n;
  logic [CODE_W-1:0] st_p_q, st_n_q, st_n_now, syn_p, syn_n;
  logic              rec, code_err, multi;
  logic [ST_W-1:0]   status_q, chk_status;
  logic [CODE_W-1:0] par_q, npar_q;

  assign bus_ready = 1'b1;
  assign beat      = bus_valid & bus_ready;

  nand_ecc_seq #(
    .DATA_W(DATA_W), .BASE_WORDS(BASE_WORDS), .AW(AW), .SPARE_N(SPARE_N),
    .SI_W(SI_W), .CMD_READ(CMD_READ), .CMD_PROG(CMD_PROG)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .page_mode(page_mode),
    .beat(beat), .cle(bus_cle), .ale(bus_ale), .data(bus_data),
    .start(start), .is_read(is_read), .main_beat(main_beat),
    .main_last(main_last), .spare_beat(spare_beat), .spare_last(spare_last),
    .word_idx(word_idx), .spare_idx(spare_idx), .idle(seq_idle)
  );

  nand_ecc_accum #(.DATA_W(DATA_W), .AW(AW), .BW(BW), .CODE_W(CODE_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(start | sw_reset), .en(main_beat),
    .word_idx(word_idx), .data(bus_data),
    .acc_p(acc_p), .acc_n(acc_n), .nxt_p(nxt_p), .nxt_n(nxt_n)
  );

  // stored code capture: byte k of the spare area lands on code bits k*DATA_W up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_p_q <= '0;
      st_n_q <= '0;
    end else if (spare_beat) begin
      for (int i = 0; i < CODE_W; i++) begin
        if (spare_idx == SI_W'(i / DATA_W)) st_p_q[i] <= bus_data[i % DATA_W];
        if (spare_idx == SI_W'(HALF_N + i / DATA_W)) st_n_q[i] <= bus_data[i % DATA_W];
      end
    end
  end

  // the final spare byte is merged combinationally so the check lands on that beat
  always_comb begin
    st_n_now = st_n_q;
    if (spare_last) begin
      for (int i = 0; i < CODE_W; i++)
        if ((i / DATA_W) == HALF_N - 1) st_n_now[i] = bus_data[i % DATA_W];
    end
  end

  nand_ecc_classify #(.CODE_W(CODE_W)) u_cls (
    .comp_p(acc_p), .comp_n(acc_n), .st_p(st_p_q), .st_n(st_n_now),
    .syn_p(syn_p), .syn_n(syn_n), .rec(rec), .code_err(code_err), .multi(multi)
  );

  always_comb begin
    chk_status = '0;
    chk_status[ST_VALID] = 1'b1;
    chk_status[ST_REC]   = rec;
    chk_status[ST_CODE]  = code_err;
    chk_status[ST_MULTI] = multi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      par_q <= '0;
      npar_q <= '0;
    end else if (sw_reset || start) begin
      status_q <= '0;
      par_q <= '0;
      npar_q <= '0;
    end else if (main_last && !is_read) begin
      status_q <= ST_W'(1) << ST_VALID;
      par_q <= nxt_p;
      npar_q <= nxt_n;
    end else if (spare_last) begin
      status_q <= chk_status;
      par_q <= syn_p;
      npar_q <= syn_n;
    end
  end

  always_comb begin
    unique case (rd_addr)
      2'd0: rd_data = REG_W'(status_q);
      2'd1: rd_data = REG_W'(par_q);
      2'd2: rd_data = REG_W'(npar_q);
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/nand_ecc_snoop_chk.sv
`timescale 1ns/1ps
module nand_ecc_snoop_chk #(
  parameter int CODE_W = 15,
  parameter int ST_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_reset,
  input logic              start,
  input logic              main_last,
  input logic              is_read,
  input logic              seq_idle,
  input logic [ST_W-1:0]   status_q,
  input logic [CODE_W-1:0] par_q,
  input logic [CODE_W-1:0] npar_q
);
  assert_swreset_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (status_q == '0 && par_q == '0 && npar_q == '0));

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !sw_reset) |=> (status_q == '0 && par_q == '0 && npar_q == '0));

  assert_write_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (main_last && !is_read && !sw_reset) |=> status_q[3]);

  assert_rec_complement_R8: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[0] |-> (par_q == ~npar_q));

  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(status_q[2:0]));

  assert_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && !start && !sw_reset) |=>
      ($stable(status_q) && $stable(par_q) && $stable(npar_q)));
endmodule

bind nand_ecc_snoop nand_ecc_snoop_chk #(.CODE_W(CODE_W), .ST_W(nand_ecc_pkg::ST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .start(start),
  .main_last(main_last), .is_read(is_read), .seq_idle(seq_idle),
  .status_q(status_q), .par_q(par_q), .npar_q(npar_q)
);

// File: tb/nand_ecc_snoop_bench.sv
`timescale 1ns/1ps
module nand_ecc_snoop_bench;
  logic        clk = 1'b0, rst_n = 1'b0, sw_reset = 1'b0;
  logic        bus_valid = 1'b0, bus_cle = 1'b0, bus_ale = 1'b0;
  logic [1:0]  page_mode = 2'd0, rd_addr = 2'd0;
  logic [7:0]  bus_data = 8'h0;
  logic        bus_ready;
  logic [31:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model state
  logic [3:0]  m_st = 0;
  logic [14:0] m_p = 0, m_n = 0;
  int          m_state = 0, m_cnt = 0, m_words = 512, m_sc = 0;
  bit          m_read = 0;
  byte unsigned m_mem[4096];
  byte unsigned m_sp[4];
  byte unsigned pg[4096];
  logic [31:0] obs[4];

  nand_ecc_snoop u_nand_ecc_snoop (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .page_mode(page_mode),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_cle(bus_cle),
    .bus_ale(bus_ale), .bus_data(bus_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void code_of(input byte unsigned a[4096], input int words,
                                  output logic [14:0] p, output logic [14:0] n);
    p = 0; n = 0;
    for (int w = 0; w < words; w++)
      for (int b = 0; b < 8; b++)
        if (a[w][b]) begin
          p = p ^ 15'((w << 3) | b);
          n = n ^ ~15'((w << 3) | b);
        end
  endfunction

  task automatic model_apply(bit sw, bit v, bit c, bit a, logic [7:0] d);
    logic [14:0] cp, cn, sp, sn;
    if (sw) begin
      m_st = 0; m_p = 0; m_n = 0; m_state = 0;
    end else if (v) begin
      if (c && (d == 8'h00 || d == 8'h80)) begin
        m_st = 0; m_p = 0; m_n = 0; m_state = 1; m_cnt = 0; m_sc = 0;
        m_read = (d == 8'h00); m_words = 512 << page_mode;
      end else if (c) begin
      end else if (a) begin
        if (m_state == 1) m_state = 2;
      end else if (m_state == 2) begin
        m_mem[m_cnt] = d; m_cnt++;
        if (m_cnt == m_words) begin
          code_of(m_mem, m_words, cp, cn);
          if (!m_read) begin m_p = cp; m_n = cn; m_st = 4'h8; m_state = 0; end
          else m_state = 3;
        end
      end else if (m_state == 3) begin
        m_sp[m_sc] = d; m_sc++;
        if (m_sc == 4) begin
          code_of(m_mem, m_words, cp, cn);
          sp = cp ^ {m_sp[1][6:0], m_sp[0]};
          sn = cn ^ {m_sp[3][6:0], m_sp[2]};
          m_p = sp; m_n = sn;
          if (sp == 0 && sn == 0) m_st = 4'h8;
          else if (sp == ~sn) m_st = 4'h9;
          else if ($countones({sp, sn}) == 1) m_st = 4'hA;
          else m_st = 4'hC;
          m_state = 0;
        end
      end
    end
  endtask

  task automatic cyc(bit sw, bit v, bit c, bit a, logic [7:0] d);
    @(negedge clk);
    sw_reset = sw; bus_valid = v; bus_cle = c; bus_ale = a; bus_data = d;
    @(posedge clk);
    #1 model_apply(sw, v, c, a, d);
  endtask

  task automatic idle(int n);
    repeat (n) cyc(0, 0, 1'($urandom), 1'($urandom), 8'($urandom));
  endtask

  // every clock: compare the read port against the model (R13, R12)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] e;
      case (rd_addr)
        2'd0: e = 32'(m_st);
        2'd1: e = 32'(m_p);
        2'd2: e = 32'(m_n);
        default: e = 0;
      endcase
      check("R13 read port vs model", rd_data, e);
      check("R12 ready high", 32'(bus_ready), 32'd1);
      obs[rd_addr] = rd_data;
      rd_addr <= rd_addr + 2'd1;
    end
  end

  task automatic send_cmd(bit rd, int mode);
    page_mode = 2'(mode);
    cyc(0, 1, 1, 0, rd ? 8'h00 : 8'h80);
  endtask

  task automatic send_addr();
    repeat (3) cyc(0, 1, 0, 1, 8'($urandom));
    cyc(0, 1, 1, 0, 8'h30);
  endtask

  // fw/fb pairs: flipped data bits (-1 none); ck: flipped stored-code bit (-1 none)
  task automatic send_body(bit rd, int words, int fw1, int fb1, int fw2, int fb2, int ck);
    logic [14:0] gp, gn;
    byte unsigned d;
    code_of(pg, words, gp, gn);
    for (int w = 0; w < words; w++) begin
      d = pg[w];
      if (w == fw1) d[fb1] = ~d[fb1];
      if (w == fw2) d[fb2] = ~d[fb2];
      if ($urandom % 5 == 0) idle(1);
      cyc(0, 1, 0, 0, d);
    end
    if (rd) begin
      if (ck >= 0 && ck < 15) gp[ck] = ~gp[ck];
      if (ck >= 15) gn[ck-15] = ~gn[ck-15];
      cyc(0, 1, 0, 0, gp[7:0]);
      cyc(0, 1, 0, 0, {1'($urandom), gp[14:8]});
      cyc(0, 1, 0, 0, gn[7:0]);
      cyc(0, 1, 0, 0, {1'($urandom), gn[14:8]});
    end
    idle(5);
  endtask

  task automatic fill(int words);
    for (int w = 0; w < words; w++) pg[w] = 8'($urandom);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [14:0] gp, gn;
    logic [31:0] s0, s1, s2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(5);
    check("R1 reset status", obs[0], 0);
    check("R1 reset parity", obs[1], 0);
    check("R1 reset inverse", obs[2], 0);

    // program sequence, with stray data before the address (R2)
    fill(512);
    code_of(pg, 512, gp, gn);
    send_cmd(0, 0);
    idle(4);
    check("R2 start clears status", obs[0], 0);
    cyc(0, 1, 0, 0, 8'hFF);
    send_addr();
    send_body(0, 512, -1, 0, -1, 0, -1);
    check("R5 write valid status", obs[0], 32'h8);
    check("R4 parity code", obs[1], 32'(gp));
    check("R4 inverse code", obs[2], 32'(gn));

    send_cmd(1, 0); send_addr(); send_body(1, 512, -1, 0, -1, 0, -1);
    check("R7 clean read status", obs[0], 32'h8);
    check("R6 clean syndrome p", obs[1], 0);
    check("R6 clean syndrome n", obs[2], 0);

    send_cmd(1, 0); send_addr(); send_body(1, 512, 37, 5, -1, 0, -1);
    check("R8 single flip status", obs[0], 32'h9);
    check("R8 single flip location", obs[1], 32'((37 << 3) | 5));

    send_cmd(1, 0); send_addr(); send_body(1, 512, 100, 2, 301, 6, -1);
    check("R10 double flip status", obs[0], 32'hC);

    send_cmd(1, 0); send_addr(); send_body(1, 512, -1, 0, -1, 0, 19);
    check("R9 code flip status", obs[0], 32'hA);
    check("R9 code flip syndrome", obs[2], 32'h10);

    // lock: stray beats after a valid result (R11)
    s0 = obs[0]; s1 = obs[1]; s2 = obs[2];
    repeat (5) cyc(0, 1, 0, 0, 8'($urandom));
    cyc(0, 1, 0, 1, 8'h12);
    cyc(0, 1, 1, 0, 8'h30);
    cyc(0, 1, 1, 0, 8'h70);
    idle(5);
    check("R11 locked status", obs[0], s0);
    check("R11 locked parity", obs[1], s1);
    check("R11 locked inverse", obs[2], s2);

    // software reset (R1)
    cyc(1, 0, 0, 0, 8'h0);
    idle(4);
    check("R1 sw reset status", obs[0], 0);
    check("R1 sw reset parity", obs[1], 0);
    repeat (8) cyc(0, 1, 0, 0, 8'($urandom));
    idle(4);
    check("R1 data after sw reset", obs[0], 0);

    // reset mid-page: remaining words must not complete a result (R1)
    send_cmd(1, 0); send_addr();
    repeat (100) cyc(0, 1, 0, 0, 8'($urandom));
    cyc(1, 0, 0, 0, 8'h0);
    repeat (420) cyc(0, 1, 0, 0, 8'($urandom));
    idle(4);
    check("R1 mid-page reset status", obs[0], 0);

    // larger page sizes (R3)
    for (int m = 1; m < 4; m++) begin
      int words;
      words = 512 << m;
      fill(words);
      code_of(pg, words, gp, gn);
      send_cmd(0, m); send_addr(); send_body(0, words, -1, 0, -1, 0, -1);
      check("R3 write status", obs[0], 32'h8);
      check("R3 parity for size", obs[1], 32'(gp));
      check("R3 inverse for size", obs[2], 32'(gn));
      send_cmd(1, m); send_addr(); send_body(1, words, words - 1, 7, -1, 0, -1);
      check("R3 last word flip status", obs[0], 32'h9);
      check("R3 last word flip location", obs[1], 32'(((words - 1) << 3) | 7));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule